// File: doc/BRIEF.md
# Adaptive Dead-Time Gate Sequencer

This block is the digital control core of a synchronous buck half-bridge driver. It receives already digitised conditions: a three-level PWM command decoded into high, low and mid flags, two logic-supply comparator flags, a bootstrap undervoltage flag, one "gate-source voltage below 1 V" flag for each switch, and a flag that says the switch node is held high. From these it produces the enables for the high-side and low-side gates. The two gates are never on together. On each PWM edge the conducting switch is turned off first. The opposite switch is turned on only once the sensed gate voltage of the switch turning off has collapsed.

The dead time therefore adapts to whatever power transistors are fitted. If a discharge flag never arrives, a cycle-count timeout turns the opposite gate on anyway and latches a sticky fault. A mid-level PWM input that lasts for a qualified hold-off time parks both gates low. A floating input is treated the same way. After power-up, or after the logic supply drops out, the PWM command is ignored until it makes a fresh low-to-high transition. A bootstrap undervoltage parks both gates. While the high-side gate is discharging, a switch node that is not held high lets the low side turn on at once, so that the bootstrap capacitor is refreshed.

States: ST_LOCK (unarmed or supply lockout, both off), ST_PARK (shutdown window or bootstrap undervoltage, both off), ST_LS_ON, ST_LS_TO_HS (low side released, waiting for its discharge), ST_HS_ON, ST_HS_TO_LS (high side released, waiting for its discharge).

Transitions are checked in priority order:
- Any state goes to ST_LOCK when not armed.
- Otherwise any state goes to ST_PARK on bootstrap undervoltage or a qualified window.
- ST_LOCK/ST_PARK go to ST_LS_TO_HS on high and to ST_HS_TO_LS on low.
- ST_LS_ON goes to ST_LS_TO_HS on high.
- ST_LS_TO_HS goes to ST_LS_ON on low, or to ST_HS_ON on low-side discharge or timeout.
- ST_HS_ON goes to ST_HS_TO_LS on low.
- ST_HS_TO_LS goes to ST_HS_ON on high, or to ST_LS_ON on high-side discharge, on a switch node that is not held high, or on timeout.

Top module: `hb_gate_sequencer`

## Requirements
- R1: After reset both enables and the fault bit are 0. The PWM command is ignored, with both gates off, until the decoded level goes from not-high to high. A level that is already high when reset is released does not count as that transition.
- R2: On a PWM high command while the low gate is on, ls_en drops one cycle after the command. hs_en rises one cycle after a cycle in which ls_vgs_low is 1 (active high = discharged). hs_en never rises in a cycle that follows one with ls_en high.
- R3: On a PWM low command while the high gate is on, hs_en drops one cycle after the command. ls_en rises one cycle after a cycle in which hs_vgs_low is 1. ls_en never rises in a cycle that follows one with hs_en high.
- R4: If the PWM command reverses while the sequencer is waiting for a discharge, the gate that was just released is enabled again on the next cycle, and the opposite gate stays off.
- R5: The decoded level is mid when pwm_mid is 1, or when pwm_hi equals pwm_lo. Both gates go off one cycle after the HOLDOFF_CYC-th consecutive mid cycle. A mid excursion of HOLDOFF_CYC-1 cycles changes no output.
- R6: A floating input (all three PWM flags 0) is decoded as mid. Once qualified, it holds both gates off until a high or low level returns.
- R7: The logic-supply lockout sets when vcc_below_off is 1 and clears only when vcc_above_on is 1. Both gates are off the cycle after it sets. Between the two thresholds the lockout keeps its state. After it clears, a new low-to-high PWM transition is needed.
- R8: bootstrap_uv at 1 turns both gates off on the next cycle. When it returns to 0, the PWM level resumes through the normal adaptive sequence.
- R9: While the sequencer waits for the high-side discharge under a low command, sw_high at 0 enables the low gate on the next cycle without the discharge flag.
- R10: If a discharge flag does not arrive, the opposite gate is enabled after DT_TIMEOUT_CYC cycles in the wait state (16 by default), and dt_fault sets at the same edge. dt_fault stays 1 until reset.
- R11: hs_en and ls_en are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pwm_hi | input | 1 | PWM command above the high threshold |
| pwm_lo | input | 1 | PWM command below the low threshold |
| pwm_mid | input | 1 | PWM command inside the shutdown window |
| vcc_below_off | input | 1 | Logic supply below its falling threshold |
| vcc_above_on | input | 1 | Logic supply above its rising threshold |
| bootstrap_uv | input | 1 | Bootstrap supply undervoltage |
| hs_vgs_low | input | 1 | High-side gate-source voltage below 1 V |
| ls_vgs_low | input | 1 | Low-side gate-source voltage below 1 V |
| sw_high | input | 1 | Switch node actively held high |
| hs_en | output | 1 | High-side gate enable |
| ls_en | output | 1 | Low-side gate enable |
| dt_fault | output | 1 | Sticky dead-time timeout fault |

## Verification
The timeout path is the hardest to reach from the ports. It needs a low command with the high-side discharge flag stuck at 0. The switch node must also be reported high for the whole window, or else the bootstrap-refresh rule ends the wait early. The stimulus holds both conditions for exactly DT_TIMEOUT_CYC cycles and expects the low gate and the fault in the following cycle. The shutdown window boundary is reached by holding a mid level for one cycle less than the hold-off, then for the full hold-off.

// File: rtl/hbgs_pkg.sv
package hbgs_pkg;

    typedef enum logic [1:0] {
        LVL_LOW  = 2'd0,
        LVL_HIGH = 2'd1,
        LVL_MID  = 2'd2
    } pwm_lvl_t;

    typedef enum logic [2:0] {
        ST_LOCK     = 3'd0,
        ST_PARK     = 3'd1,
        ST_LS_ON    = 3'd2,
        ST_LS_TO_HS = 3'd3,
        ST_HS_ON    = 3'd4,
        ST_HS_TO_LS = 3'd5
    } seq_state_t;

endpackage

// File: rtl/hbgs_window.sv
module hbgs_window
    import hbgs_pkg::*;
#(
    parameter int HOLDOFF_CYC = 10
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pwm_hi,
    input  logic     pwm_lo,
    input  logic     pwm_mid,
    output pwm_lvl_t lvl,
    output logic     shut_now
);
    localparam int CW = (HOLDOFF_CYC > 1) ? $clog2(HOLDOFF_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(HOLDOFF_CYC - 1);

    logic [CW-1:0] mid_cnt;

    // decode: contradictory or empty flags count as the mid window
    always_comb begin
        if (pwm_mid || (pwm_hi == pwm_lo)) begin
            lvl = LVL_MID;
        end else if (pwm_hi) begin
            lvl = LVL_HIGH;
        end else begin
            lvl = LVL_LOW;
        end
    end

    // consecutive mid cycles, saturating at the qualification point
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid_cnt <= '0;
        end else if (lvl != LVL_MID) begin
            mid_cnt <= '0;
        end else if (mid_cnt != LAST) begin
            mid_cnt <= mid_cnt + CW'(1);
        end
    end

    assign shut_now = (lvl == LVL_MID) && (mid_cnt == LAST);

endmodule

// File: rtl/hbgs_power_gate.sv
module hbgs_power_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic vcc_below_off,
    input  logic vcc_above_on,
    input  logic lvl_high,
    output logic run_ok
);
    logic uv_q;
    logic uv_next;
    logic prev_high_q;
    logic armed_q;
    logic rise;

    always_comb begin
        if (vcc_below_off) begin
            uv_next = 1'b1;
        end else if (vcc_above_on) begin
            uv_next = 1'b0;
        end else begin
            uv_next = uv_q;
        end
    end

    assign rise   = lvl_high && !prev_high_q;
    assign run_ok = !uv_next && (armed_q || rise);

    // prev_high_q starts at 1 so a level held high through reset never arms
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uv_q        <= 1'b1;
            prev_high_q <= 1'b1;
            armed_q     <= 1'b0;
        end else begin
            uv_q        <= uv_next;
            prev_high_q <= lvl_high;
            armed_q     <= run_ok;
        end
    end

endmodule

// File: rtl/hbgs_dt_timer.sv
module hbgs_dt_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int TW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [TW-1:0] LAST = TW'(LIMIT - 1);

    logic [TW-1:0] cnt;

    assign expired = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + TW'(1);
        end
    end

endmodule

// File: rtl/hb_gate_sequencer.sv
module hb_gate_sequencer
    import hbgs_pkg::*;
#(
    parameter int HOLDOFF_CYC    = 10,
    parameter int DT_TIMEOUT_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_hi,
    input  logic pwm_lo,
    input  logic pwm_mid,
    input  logic vcc_below_off,
    input  logic vcc_above_on,
    input  logic bootstrap_uv,
    input  logic hs_vgs_low,
    input  logic ls_vgs_low,
    input  logic sw_high,
    output logic hs_en,
    output logic ls_en,
    output logic dt_fault
);
    pwm_lvl_t   lvl;
    logic       shut_now;
    logic       run_ok;
    logic       dt_expired;
    logic       waiting;
    logic       fault_set;
    seq_state_t st_q;
    seq_state_t st_nxt;

    hbgs_window #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_window (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwm_hi   (pwm_hi),
        .pwm_lo   (pwm_lo),
        .pwm_mid  (pwm_mid),
        .lvl      (lvl),
        .shut_now (shut_now)
    );

    hbgs_power_gate u_power (
        .clk           (clk),
        .rst_n         (rst_n),
        .vcc_below_off (vcc_below_off),
        .vcc_above_on  (vcc_above_on),
        .lvl_high      (lvl == LVL_HIGH),
        .run_ok        (run_ok)
    );

    assign waiting = (st_q == ST_LS_TO_HS) || (st_q == ST_HS_TO_LS);

    hbgs_dt_timer #(.LIMIT(DT_TIMEOUT_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (waiting),
        .expired (dt_expired)
    );

    // next state: lockout, then park, then the adaptive sequence
    always_comb begin
        st_nxt    = st_q;
        fault_set = 1'b0;
        if (!run_ok) begin
            st_nxt = ST_LOCK;
        end else if (bootstrap_uv || shut_now) begin
            st_nxt = ST_PARK;
        end else begin
            unique case (st_q)
                ST_LOCK, ST_PARK: begin
                    if (lvl == LVL_HIGH) begin
                        st_nxt = ST_LS_TO_HS;
                    end else if (lvl == LVL_LOW) begin
                        st_nxt = ST_HS_TO_LS;
                    end
                end
                ST_LS_ON: begin
                    if (lvl == LVL_HIGH) begin
                        st_nxt = ST_LS_TO_HS;
                    end
                end
                ST_LS_TO_HS: begin
                    if (lvl == LVL_LOW) begin
                        st_nxt = ST_LS_ON;
                    end else if (ls_vgs_low) begin
                        st_nxt = ST_HS_ON;
                    end else if (dt_expired) begin
                        st_nxt    = ST_HS_ON;
                        fault_set = 1'b1;
                    end
                end
                ST_HS_ON: begin
                    if (lvl == LVL_LOW) begin
                        st_nxt = ST_HS_TO_LS;
                    end
                end
                ST_HS_TO_LS: begin
                    if (lvl == LVL_HIGH) begin
                        st_nxt = ST_HS_ON;
                    end else if (hs_vgs_low || !sw_high) begin
                        st_nxt = ST_LS_ON;
                    end else if (dt_expired) begin
                        st_nxt    = ST_LS_ON;
                        fault_set = 1'b1;
                    end
                end
                default: st_nxt = ST_LOCK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_LOCK;
            dt_fault <= 1'b0;
        end else begin
            st_q <= st_nxt;
            if (fault_set) begin
                dt_fault <= 1'b1;
            end
        end
    end

    // gate enables decode the registered state only
    always_comb begin
        hs_en = 1'b0;
        ls_en = 1'b0;
        unique case (st_q)
            ST_HS_ON: hs_en = 1'b1;
            ST_LS_ON: ls_en = 1'b1;
            default: begin
                hs_en = 1'b0;
                ls_en = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/hbgs_checker.sv
module hbgs_checker (
    input logic clk,
    input logic rst_n,
    input logic vcc_below_off,
    input logic bootstrap_uv,
    input logic hs_en,
    input logic ls_en,
    input logic dt_fault
);
    p_no_overlap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_en && ls_en));

    p_ls_off_before_hs_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_en) |-> $past(!ls_en));

    p_hs_off_before_ls_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_en) |-> $past(!hs_en));

    p_supply_lockout_r7: assert property (@(posedge clk) disable iff (!rst_n)
        vcc_below_off |=> (!hs_en && !ls_en));

    p_boot_park_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bootstrap_uv |=> (!hs_en && !ls_en));

    p_fault_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dt_fault |=> dt_fault);

endmodule

bind hb_gate_sequencer hbgs_checker u_hbgs_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .vcc_below_off (vcc_below_off),
    .bootstrap_uv  (bootstrap_uv),
    .hs_en         (hs_en),
    .ls_en         (ls_en),
    .dt_fault      (dt_fault)
);

// File: tb/test_hb_gate_sequencer.sv
`timescale 1ns/1ps
module test_hb_gate_sequencer;

    localparam int HOLD = 10;
    localparam int TMO  = 16;

    typedef struct {
        logic  hs;
        logic  ls;
        logic  flt;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_hi, pwm_lo, pwm_mid, vcc_below_off, vcc_above_on;
    logic bootstrap_uv, hs_vgs_low, ls_vgs_low, sw_high;
    logic hs_en, ls_en, dt_fault;

    logic s_hi, s_lo, s_mid, s_below, s_above, s_buv, s_hsv, s_lsv, s_sw;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    hb_gate_sequencer #(.HOLDOFF_CYC(HOLD), .DT_TIMEOUT_CYC(TMO)) i_hb_gate_sequencer (
        .clk           (clk),
        .rst_n         (rst_n),
        .pwm_hi        (pwm_hi),
        .pwm_lo        (pwm_lo),
        .pwm_mid       (pwm_mid),
        .vcc_below_off (vcc_below_off),
        .vcc_above_on  (vcc_above_on),
        .bootstrap_uv  (bootstrap_uv),
        .hs_vgs_low    (hs_vgs_low),
        .ls_vgs_low    (ls_vgs_low),
        .sw_high       (sw_high),
        .hs_en         (hs_en),
        .ls_en         (ls_en),
        .dt_fault      (dt_fault)
    );

    task automatic compare(input logic ah, al, af, eh, el, ef, input string tag);
        checks++;
        if (ah !== eh || al !== el || af !== ef) begin
            errors++;
            $display("FAIL %s: hs/ls/fault actual=%b%b%b expected=%b%b%b",
                     tag, ah, al, af, eh, el, ef);
        end
    endtask

    task automatic apply();
        pwm_hi = s_hi; pwm_lo = s_lo; pwm_mid = s_mid;
        vcc_below_off = s_below; vcc_above_on = s_above;
        bootstrap_uv = s_buv; hs_vgs_low = s_hsv; ls_vgs_low = s_lsv; sw_high = s_sw;
    endtask

    // driver: one stimulus cycle, expectation for the following edge
    task automatic tick(input logic eh, el, ef, input string tag);
        exp_t e;
        @(negedge clk);
        apply();
        e.hs = eh; e.ls = el; e.flt = ef; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic ticks(input int n, input logic eh, el, ef, input string tag);
        for (int i = 0; i < n; i++) tick(eh, el, ef, tag);
    endtask

    task automatic pwm(input logic h, l, m);
        s_hi = h; s_lo = l; s_mid = m;
    endtask

    // monitor: every cycle overlap check, plus scoreboard pop
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n) begin
                checks++;
                if (hs_en && ls_en) begin
                    errors++;
                    $display("FAIL R11 overlap: hs/ls actual=%b%b expected=not 11", hs_en, ls_en);
                end
            end
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                compare(hs_en, ls_en, dt_fault, e.hs, e.ls, e.flt, e.tag);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        pwm(1'b1, 1'b0, 1'b0);
        s_below = 1'b1; s_above = 1'b0; s_buv = 1'b0;
        s_hsv = 1'b1; s_lsv = 1'b1; s_sw = 1'b0;
        apply();
        repeat (3) @(negedge clk);
        compare(hs_en, ls_en, dt_fault, 1'b0, 1'b0, 1'b0, "R1 reset state");
        rst_n = 1'b1;

        // R1: level held high through reset does not arm; low is ignored
        s_below = 1'b0; s_above = 1'b1;
        ticks(3, 0, 0, 0, "R1 held-high ignored");
        pwm(1'b0, 1'b1, 1'b0);
        ticks(2, 0, 0, 0, "R1 low ignored before arming");
        pwm(1'b1, 1'b0, 1'b0);
        tick(0, 0, 0, "R1 first rise starts sequence");
        tick(1, 0, 0, "R2 high side after low-side flag");

        // R3: adaptive high-to-low
        pwm(1'b0, 1'b1, 1'b0); s_hsv = 1'b0; s_sw = 1'b1;
        ticks(3, 0, 0, 0, "R3 waits for high-side discharge");
        s_hsv = 1'b1;
        tick(0, 1, 0, "R3 low side after high-side flag");

        // R2: adaptive low-to-high
        pwm(1'b1, 1'b0, 1'b0); s_lsv = 1'b0;
        ticks(3, 0, 0, 0, "R2 waits for low-side discharge");
        s_lsv = 1'b1;
        tick(1, 0, 0, "R2 high side after low-side flag");

        // R9: switch node not held high forces the low side
        pwm(1'b0, 1'b1, 1'b0); s_hsv = 1'b0; s_sw = 1'b1;
        tick(0, 0, 0, "R9 entering wait");
        s_sw = 1'b0;
        tick(0, 1, 0, "R9 bootstrap refresh");
        s_hsv = 1'b1; s_sw = 1'b1;

        // R4: reversal while waiting
        pwm(1'b1, 1'b0, 1'b0); s_lsv = 1'b0;
        tick(0, 0, 0, "R4 low released");
        pwm(1'b0, 1'b1, 1'b0);
        tick(0, 1, 0, "R4 low side back");
        s_lsv = 1'b1;
        pwm(1'b1, 1'b0, 1'b0);
        ticks(1, 0, 0, 0, "R2 toward high");
        tick(1, 0, 0, "R2 high side on");
        pwm(1'b0, 1'b1, 1'b0); s_hsv = 1'b0;
        tick(0, 0, 0, "R4 high released");
        pwm(1'b1, 1'b0, 1'b0);
        tick(1, 0, 0, "R4 high side back");
        pwm(1'b0, 1'b1, 1'b0); s_hsv = 1'b1;
        tick(0, 0, 0, "R3 toward low");
        tick(0, 1, 0, "R3 low side on");

        // R5: one cycle short of the hold-off does nothing
        pwm(1'b0, 1'b0, 1'b1);
        ticks(HOLD - 1, 0, 1, 0, "R5 short mid window");
        pwm(1'b0, 1'b1, 1'b0);
        tick(0, 1, 0, "R5 short mid ignored");

        // R6: floating input qualifies after the hold-off
        pwm(1'b0, 1'b0, 1'b0);
        ticks(HOLD - 1, 0, 1, 0, "R6 floating before hold-off");
        tick(0, 0, 0, "R6 floating parks both gates");
        ticks(2, 0, 0, 0, "R6 stays parked");
        pwm(1'b0, 1'b1, 1'b0);
        tick(0, 0, 0, "R6 resume through wait");
        tick(0, 1, 0, "R6 low side resumes");

        // R8: bootstrap undervoltage
        s_buv = 1'b1;
        ticks(2, 0, 0, 0, "R8 boot uv parks");
        s_buv = 1'b0;
        tick(0, 0, 0, "R8 resume through wait");
        tick(0, 1, 0, "R8 low side resumes");
        pwm(1'b1, 1'b0, 1'b0);
        tick(0, 0, 0, "R2 toward high");
        tick(1, 0, 0, "R2 high side on");
        s_buv = 1'b1;
        tick(0, 0, 0, "R8 boot uv drops high side");
        s_buv = 1'b0;
        tick(0, 0, 0, "R8 resume high through wait");
        tick(1, 0, 0, "R8 high side resumes");

        // R10: stuck discharge flag with switch node held high
        pwm(1'b0, 1'b1, 1'b0); s_hsv = 1'b0; s_sw = 1'b1;
        ticks(TMO, 0, 0, 0, "R10 waiting before timeout");
        tick(0, 1, 1, "R10 timeout enables low side and sets fault");
        s_hsv = 1'b1;
        tick(0, 1, 1, "R10 fault sticky");

        // R7: supply lockout with hysteresis
        s_below = 1'b1; s_above = 1'b0;
        tick(0, 0, 1, "R7 lockout");
        s_below = 1'b0;
        pwm(1'b1, 1'b0, 1'b0);
        ticks(2, 0, 0, 1, "R7 between thresholds stays locked");
        s_above = 1'b1;
        ticks(2, 0, 0, 1, "R7 needs a new rising edge");
        pwm(1'b0, 1'b1, 1'b0);
        tick(0, 0, 1, "R7 low ignored after release");
        pwm(1'b1, 1'b0, 1'b0);
        tick(0, 0, 1, "R7 rearm on rise");
        tick(1, 0, 1, "R7 running again");
        s_above = 1'b0;
        ticks(2, 1, 0, 1, "R7 between thresholds keeps running");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule